// File: doc/BRIEF.md
# Dual-Source Interrupt Combiner with Cause Status

This block merges the interrupt requests of a serial communications controller and a parallel printer port onto one active-low interrupt line for the host processor. The serial controller's own active-low interrupt output passes straight through. The printer raises a request only while a latched enable bit is set and the printer reports that it is not busy. The result is a level-sensitive request. It stays asserted while any qualified source remains and releases in the same cycle the last one goes away.

Software finds the cause by reading a status byte. One bit is a general "interrupt pending" flag. A second bit says that the printer is among the causes. When the flag is set and the printer bit is clear, the serial controller raised the request, and its own status register identifies it. The printer enable is written through a one-bit control write port. The status byte is captured from the live request state on a read strobe. Reading has no side effect on the request line or on the enable.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the printer enable is 0, the captured status byte is 0x00, and `irq_n` is 1 while `ser_irq_n` is 1.
- R2: While the printer enable is 1 and `prn_busy` is 0, `irq_n` is 0 in that same cycle.
- R3: While `prn_busy` is 1, the printer causes no request: with `ser_irq_n` at 1, `irq_n` is 1 whatever the enable.
- R4: While the printer enable is 0, the printer causes no request: with `ser_irq_n` at 1, `irq_n` is 1 whatever `prn_busy`.
- R5: While `ser_irq_n` is 0, `irq_n` is 0, independent of the enable and of `prn_busy`.
- R6: `irq_n` is level-sensitive with no storage. It returns to 1 in the same cycle that no qualified source remains.
- R7: A clock edge with `stat_rd` at 1 loads `stat_q` with the status at that edge. Bit 4 (FLAG_BIT) is 1 exactly when `irq_n` is 0. Bit 3 (CAUSE_BIT) is 1 exactly when the printer is qualified (enable 1, `prn_busy` 0). All other bits are 0.
- R8: A status read has no side effect. `irq_n` and the printer enable keep their values across the read.
- R9: A clock edge with `ctl_wr` at 1 loads the printer enable from `ctl_en`. Without `ctl_wr`, the enable holds. When a read and a write happen at the same edge, the read returns the status from before the write.
- R10: `stat_q` holds its value on every edge where `stat_rd` is 0, even while the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Printer interrupt enable value written by `ctl_wr` |
| ser_irq_n | input | 1 | Active-low interrupt from the serial controller |
| prn_busy | input | 1 | Printer BUSY, 1 = busy |
| stat_rd | input | 1 | Status read strobe |
| irq_n | output | 1 | Combined active-low interrupt request |
| stat_q | output | DATA_W | Status byte captured at the last read |

## Verification
On every cycle, the checker enforces the forcing relations between the inputs, the internal enable and `irq_n`. It also checks that each read loads the flag and the printer-cause bit from the state one edge earlier, that `stat_q` holds between reads, and that a write lands in the enable. What only the bench scenarios can show is the full truth table over enable, BUSY and serial request, read back through the status port. The same applies to the ordering of a read and a write at one edge, to the unused status bits staying 0, and to a read leaving the request line untouched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Source qualification result shared by the combiner and the status capture.
    typedef struct packed {
        logic ser_act;   // serial controller requesting
        logic prn_act;   // printer qualified and requesting
        logic any_act;   // at least one qualified source
    } irq_src_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
// Control latch holding the printer interrupt enable.
module irq_agg_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_en_bit,
    output logic prn_en
);
    typedef struct packed {
        logic prn_en;
    } ctrl_t;

    ctrl_t st_d;
    ctrl_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.prn_en = wr_en_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prn_en = st_q.prn_en;
endmodule

// File: rtl/irq_agg_combine.sv
// Qualifies both sources and forms the combined level request.
module irq_agg_combine
    import irq_agg_pkg::*;
(
    input  logic     ser_irq_n,
    input  logic     prn_busy,
    input  logic     prn_en,
    output irq_src_t src,
    output logic     irq_n
);
    always_comb begin
        src         = '0;
        src.ser_act = ~ser_irq_n;
        src.prn_act = prn_en & ~prn_busy;
        src.any_act = src.ser_act | src.prn_act;
    end

    assign irq_n = ~src.any_act;
endmodule

// File: rtl/irq_agg_status.sv
// Captures the status snapshot on a read strobe.
module irq_agg_status
    import irq_agg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FLAG_BIT  = 4,
    parameter int CAUSE_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  irq_src_t          src,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } stat_t;

    logic [DATA_W-1:0] snap;
    stat_t st_d;
    stat_t st_q;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        if (gi == FLAG_BIT) begin : g_flag
            assign snap[gi] = src.any_act;
        end else if (gi == CAUSE_BIT) begin : g_cause
            assign snap[gi] = src.prn_act;
        end else begin : g_zero
            assign snap[gi] = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            st_d.rdata = snap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FLAG_BIT  = 4,
    parameter int CAUSE_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic              ser_irq_n,
    input  logic              prn_busy,
    input  logic              stat_rd,
    output logic              irq_n,
    output logic [DATA_W-1:0] stat_q
);
    logic     prn_en_q;
    irq_src_t src;

    irq_agg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (ctl_wr),
        .wr_en_bit (ctl_en),
        .prn_en    (prn_en_q)
    );

    irq_agg_combine u_comb (
        .ser_irq_n (ser_irq_n),
        .prn_busy  (prn_busy),
        .prn_en    (prn_en_q),
        .src       (src),
        .irq_n     (irq_n)
    );

    irq_agg_status #(
        .DATA_W    (DATA_W),
        .FLAG_BIT  (FLAG_BIT),
        .CAUSE_BIT (CAUSE_BIT)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (stat_rd),
        .src    (src),
        .rdata  (stat_q)
    );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int DATA_W    = 8,
    parameter int FLAG_BIT  = 4,
    parameter int CAUSE_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic              ctl_en,
    input logic              ser_irq_n,
    input logic              prn_busy,
    input logic              stat_rd,
    input logic              irq_n,
    input logic [DATA_W-1:0] stat_q,
    input logic              prn_en_q
);
    AST_PRN_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n) (prn_en_q && !prn_busy) |-> !irq_n); // R2
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (prn_busy && ser_irq_n) |-> irq_n); // R3
    AST_EN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (!prn_en_q && ser_irq_n) |-> irq_n); // R4
    AST_SER_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n) (!ser_irq_n) |-> !irq_n); // R5
    AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) stat_rd |=> (stat_q[FLAG_BIT] == !$past(irq_n))); // R7
    AST_CAUSE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) stat_rd |=> (stat_q[CAUSE_BIT] == $past(prn_en_q && !prn_busy))); // R7
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ctl_wr |=> $stable(prn_en_q)); // R8
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |=> (prn_en_q == $past(ctl_en))); // R9
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !stat_rd |=> $stable(stat_q)); // R10
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .DATA_W    (DATA_W),
    .FLAG_BIT  (FLAG_BIT),
    .CAUSE_BIT (CAUSE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_en    (ctl_en),
    .ser_irq_n (ser_irq_n),
    .prn_busy  (prn_busy),
    .stat_rd   (stat_rd),
    .irq_n     (irq_n),
    .stat_q    (stat_q),
    .prn_en_q  (prn_en_q)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    localparam int DW = 8;
    localparam int FB = 4;
    localparam int CB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic ctl_en = 1'b0;
    logic ser_irq_n = 1'b1;
    logic prn_busy = 1'b0;
    logic stat_rd = 1'b0;
    logic irq_n;
    logic [DW-1:0] stat_q;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_aggregator #(.DATA_W(DW), .FLAG_BIT(FB), .CAUSE_BIT(CB)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .ser_irq_n(ser_irq_n), .prn_busy(prn_busy), .stat_rd(stat_rd),
        .irq_n(irq_n), .stat_q(stat_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_irq_n(input int en, input int busy, input int ser_n);
        return ((ser_n == 0) || (en == 1 && busy == 0)) ? 0 : 1;
    endfunction

    function automatic int exp_stat(input int en, input int busy, input int ser_n);
        int v = 0;
        if (exp_irq_n(en, busy, ser_n) == 0) v += (1 << FB);
        if (en == 1 && busy == 0) v += (1 << CB);
        return v;
    endfunction

    task automatic set_en(input logic v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_en = v;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_en = ~v;
    endtask

    task automatic do_read;
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq_n after reset", int'(irq_n), 1);
        chk("R1 stat_q after reset", int'(stat_q), 0);
        // R1/R4: enable is 0 after reset, so an idle printer raises nothing
        prn_busy = 1'b0;
        #1;
        chk("R1 printer off after reset", int'(irq_n), 1);

        for (int en = 0; en < 2; en++) begin
            set_en(logic'(en));
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 2; s++) begin
                    @(negedge clk);
                    prn_busy = logic'(b); ser_irq_n = logic'(s);
                    #1;
                    // R2 R3 R4 R5 irq_n truth table
                    chk($sformatf("R2/R3/R4/R5 irq_n en=%0d busy=%0d ser_n=%0d", en, b, s),
                        int'(irq_n), exp_irq_n(en, b, s));
                    do_read();
                    #1;
                    chk($sformatf("R7 status en=%0d busy=%0d ser_n=%0d", en, b, s),
                        int'(stat_q), exp_stat(en, b, s));
                    chk("R8 irq_n unchanged by read", int'(irq_n), exp_irq_n(en, b, s));
                    // R10: inputs flip, no read, capture must hold
                    @(negedge clk);
                    prn_busy = ~prn_busy; ser_irq_n = ~ser_irq_n;
                    @(negedge clk);
                    #1;
                    chk("R10 stat_q held without read", int'(stat_q), exp_stat(en, b, s));
                    // R8: enable unchanged by the earlier read (seen via irq_n)
                    chk("R8 enable kept after read", int'(irq_n), exp_irq_n(en, 1 - b, 1 - s));
                end
            end
        end

        // R6: level drop in the same cycle the last source leaves
        set_en(1'b1);
        @(negedge clk);
        prn_busy = 1'b0; ser_irq_n = 1'b0;
        #1;
        chk("R6 both sources asserted", int'(irq_n), 0);
        ser_irq_n = 1'b1;
        #1;
        chk("R6 printer alone keeps request", int'(irq_n), 0);
        prn_busy = 1'b1;
        #1;
        chk("R6 release immediately", int'(irq_n), 1);
        prn_busy = 1'b0;
        #1;
        chk("R6 re-assert on busy drop", int'(irq_n), 0);

        // R9: read and write at the same edge returns pre-write status
        set_en(1'b0);
        @(negedge clk);
        prn_busy = 1'b0; ser_irq_n = 1'b1;
        ctl_wr = 1'b1; ctl_en = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_en = 1'b0; stat_rd = 1'b0;
        #1;
        chk("R9 same-edge read sees old enable", int'(stat_q), 0);
        chk("R9 write took effect", int'(irq_n), 0);
        // R9: enable holds with ctl_en toggling but no strobe
        @(negedge clk);
        ctl_en = 1'b0;
        @(negedge clk);
        #1;
        chk("R9 enable holds without strobe", int'(irq_n), 0);
        do_read();
        #1;
        chk("R9 status after write", int'(stat_q), (1 << FB) + (1 << CB));

        // R1: reset mid-run clears enable and status
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 stat_q cleared by reset", int'(stat_q), 0);
        chk("R1 enable cleared by reset", int'(irq_n), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule